// File: doc/BRIEF.md
# Chien Search Bit Corrector

This block takes the coefficients of an error locator polynomial over GF(2^m) and walks every bit position of a codeword, one position per clock. For position `p` (counted from 1 to the code length) it evaluates the polynomial at the field element alpha^(p-1). A zero result marks that position as being in error. In the same cycle it asks the page buffer for the stored bit of that position. When the bit comes back, the block flips it if the position was marked and sends it out on a corrected-bit stream, in buffer order.

Multiplication is done in the logarithm domain. Each non-zero coefficient is turned into its exponent by a table. The exponent of alpha^((p-1)·j) is added to it modulo 2^m - 1. The sum is turned back into a field element by a second table. A zero coefficient skips the tables and adds nothing. The tables are computed when the design is elaborated, from the field width and the primitive polynomial.

At the end of a search the block pulses `done` together with the last corrected bit. It also reports `fail` when the number of roots found differs from the degree of the polynomial. The degree is the index of the highest non-zero coefficient. A failed search means the errors cannot be corrected.

Top module: `chienCorrector`

## Requirements
- R1: After reset, `bufRdEn`, `outValid`, `done` and `fail` are 0.
- R2: When `start` is seen while idle, the block latches `lambdaCoef`. On the following `CODE_LEN` consecutive cycles it asserts `bufRdEn` with `bufRdAddr` going 0, 1, …, `CODE_LEN-1`. Address `a` belongs to position `p = a+1`.
- R3: The buffer returns `bufRdData` one cycle after the read. The corrected bit for address `a` appears on `outBit`, with `outValid` high, two cycles after the cycle that read `a`. Its value is `bufRdData` XOR (1 + sum over j of Lambda_j·(alpha^(p-1))^j == 0). Lambda_j is held in `lambdaCoef[(j-1)*M +: M]`, for j from 1 to T. Lambda_0 is implicitly 1, and alpha is the field element 2 (the polynomial x).
- R4: A zero coefficient adds nothing to the sum. With every coefficient zero, each output bit equals the stored bit and `fail` is 0.
- R5: `done` is high for exactly one cycle, the same cycle as the last corrected bit.
- R6: While `done` is high, `fail` is 1 exactly when the number of marked positions differs from the index of the highest non-zero coefficient (0 when all coefficients are zero). `fail` is cleared when the next search starts.
- R7: `start` has no effect while a search is in progress. Holding it high during a search does not restart the address sequence.
- R8: Changes on `lambdaCoef` after the search has started have no effect on its output bits or on `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| lambdaCoef | input | T*M | Coefficients Lambda_1..Lambda_T, Lambda_j at bits (j-1)*M upward |
| bufRdEn | output | 1 | Page-buffer read request |
| bufRdAddr | output | ADDR_W | Page-buffer bit address (position minus one) |
| bufRdData | input | 1 | Stored bit, valid the cycle after the request |
| outValid | output | 1 | Corrected bit valid |
| outBit | output | 1 | Corrected bit |
| done | output | 1 | One-cycle pulse with the last corrected bit |
| fail | output | 1 | Root count differs from polynomial degree |

## Verification
The assertions assume that `bufRdData` always returns one cycle after a request, and that `start` is driven only by synchronous logic. The bench holds to both: it models the page buffer as a registered memory and changes every input on the falling edge. The checks on the read sequence and on the stream timing also assume a search is not cut short. So the bench waits through each search, even when it holds `start` high or changes `lambdaCoef` part way through.

// File: rtl/chienPkg.sv
package chienPkg;
  typedef struct packed {
    logic load;    // latch coefficients, clear accumulators
    logic step;    // evaluate current position, advance exponents
    logic finish;  // publish result of the completed search
  } chienStrobeT;
endpackage

// File: rtl/chienControl.sv
module chienControl
  import chienPkg::*;
#(
  parameter int CODE_LEN = 31,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  output chienStrobeT       ctl,
  output logic              done
);
  typedef enum logic [1:0] {IDLE, RUN, DRAIN} stateT;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CODE_LEN - 1);

  stateT state;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    ctl.load   = (state == IDLE) && start;
    ctl.step   = (state == RUN);
    ctl.finish = (state == DRAIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      addr  <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.finish;
      unique case (state)
        IDLE: if (start) begin
          state <= RUN;
          addr  <= '0;
        end
        RUN: begin
          if (addr == LAST_ADDR) state <= DRAIN;
          else addr <= addr + 1'b1;
        end
        DRAIN: state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign bufRdEn   = (state == RUN);
  assign bufRdAddr = addr;
endmodule

// File: rtl/chienDatapath.sv
module chienDatapath
  import chienPkg::*;
#(
  parameter int M         = 5,
  parameter int PRIM_POLY = 'h25,
  parameter int T         = 3,
  parameter int CNT_W     = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  chienStrobeT    ctl,
  input  logic [T*M-1:0] lambdaCoef,
  input  logic           bufRdData,
  output logic           outValid,
  output logic           outBit,
  output logic           fail
);
  localparam int Q = (1 << M) - 1;
  localparam logic [M-1:0] POLY_LOW = M'(PRIM_POLY);

  function automatic logic [Q*M-1:0] buildExp();
    logic [Q*M-1:0] tab = '0;
    logic [M-1:0] v = M'(1);
    for (int k = 0; k < Q; k++) begin
      tab[k*M +: M] = v;
      v = {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY_LOW : '0);
    end
    return tab;
  endfunction

  localparam logic [Q*M-1:0] EXP_TAB = buildExp();

  function automatic logic [(Q+1)*M-1:0] buildLog();
    logic [(Q+1)*M-1:0] tab = '0;
    for (int k = 0; k < Q; k++) begin
      tab[int'(EXP_TAB[k*M +: M])*M +: M] = M'(k);
    end
    return tab;
  endfunction

  localparam logic [(Q+1)*M-1:0] LOG_TAB = buildLog();

  logic [M-1:0] coefQ  [1:T];
  logic [M-1:0] expAcc [1:T];
  logic [M-1:0] evalSum;
  logic         isRoot;
  logic [CNT_W-1:0] rootCnt, degree;
  logic         pendValid, pendRoot;

  // Log-domain evaluation of 1 + sum Lambda_j * x^j at the current position
  always_comb begin
    evalSum = M'(1);
    for (int j = 1; j <= T; j++) begin
      logic [M:0] e;
      e = {1'b0, LOG_TAB[int'(coefQ[j])*M +: M]} + {1'b0, expAcc[j]};
      if (e >= (M+1)'(Q)) e = e - (M+1)'(Q);
      if (coefQ[j] != '0) evalSum = evalSum ^ EXP_TAB[int'(e)*M +: M];
    end
    isRoot = (evalSum == '0);
  end

  always_comb begin
    degree = '0;
    for (int j = 1; j <= T; j++)
      if (coefQ[j] != '0) degree = CNT_W'(j);
  end

  generate
    for (genvar g = 1; g <= T; g++) begin : gTerm
      logic [M:0] nextExp;
      assign nextExp = {1'b0, expAcc[g]} + (M+1)'(g);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          coefQ[g]  <= '0;
          expAcc[g] <= '0;
        end else if (ctl.load) begin
          coefQ[g]  <= lambdaCoef[(g-1)*M +: M];
          expAcc[g] <= '0;
        end else if (ctl.step) begin
          expAcc[g] <= (nextExp >= (M+1)'(Q)) ? M'(nextExp - (M+1)'(Q)) : M'(nextExp);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rootCnt   <= '0;
      pendValid <= 1'b0;
      pendRoot  <= 1'b0;
      outValid  <= 1'b0;
      outBit    <= 1'b0;
      fail      <= 1'b0;
    end else begin
      pendValid <= ctl.step;
      pendRoot  <= ctl.step & isRoot;
      outValid  <= pendValid;
      outBit    <= pendValid & (bufRdData ^ pendRoot);
      if (ctl.load) begin
        rootCnt <= '0;
        fail    <= 1'b0;
      end else if (ctl.step && isRoot) begin
        rootCnt <= rootCnt + 1'b1;
      end
      if (ctl.finish) fail <= (rootCnt != degree);
    end
  end
endmodule

// File: rtl/chienCorrector.sv
module chienCorrector
  import chienPkg::*;
#(
  parameter int M         = 5,
  parameter int PRIM_POLY = 'h25,
  parameter int T         = 3,
  parameter int CODE_LEN  = 31,
  localparam int ADDR_W   = $clog2(CODE_LEN),
  localparam int CNT_W    = $clog2(CODE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [T*M-1:0]    lambdaCoef,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  input  logic              bufRdData,
  output logic              outValid,
  output logic              outBit,
  output logic              done,
  output logic              fail
);
  chienStrobeT ctl;

  chienControl #(.CODE_LEN(CODE_LEN), .ADDR_W(ADDR_W)) uCtl (
    .clk(clk), .rstN(rstN), .start(start),
    .bufRdEn(bufRdEn), .bufRdAddr(bufRdAddr), .ctl(ctl), .done(done)
  );

  chienDatapath #(.M(M), .PRIM_POLY(PRIM_POLY), .T(T), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lambdaCoef(lambdaCoef),
    .bufRdData(bufRdData), .outValid(outValid), .outBit(outBit), .fail(fail)
  );
endmodule

// File: rtl/chienCorrectorChk.sv
module chienCorrectorChk #(
  parameter int CODE_LEN = 31,
  parameter int ADDR_W   = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              bufRdEn,
  input logic [ADDR_W-1:0] bufRdAddr,
  input logic              outValid,
  input logic              done
);
  // R2
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufRdEn && $past(bufRdEn)) |-> (bufRdAddr == $past(bufRdAddr) + 1'b1));

  // R3
  out_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(bufRdEn, 2));

  // R5
  done_with_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outValid && !$past(done)));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufRdEn && start && bufRdAddr != ADDR_W'(CODE_LEN - 1)) |=> (bufRdEn && bufRdAddr != '0));
endmodule

bind chienCorrector chienCorrectorChk #(.CODE_LEN(CODE_LEN), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_chienCorrector.sv
module tb_chienCorrector;
  localparam int M = 5;
  localparam int PRIM = 'h25;
  localparam int T = 3;
  localparam int N = 31;
  localparam int Q = (1 << M) - 1;
  localparam int AW = $clog2(N);

  logic clk = 0, rstN = 0, start = 0;
  logic [T*M-1:0] lambdaCoef = '0;
  logic bufRdEn, bufRdData, outValid, outBit, done, fail;
  logic [AW-1:0] bufRdAddr;

  int checks = 0, failures = 0;
  bit mem [N];
  bit expBits [N];
  bit expFail;

  always #5 clk = ~clk;

  chienCorrector #(.M(M), .PRIM_POLY(PRIM), .T(T), .CODE_LEN(N)) dut (.*);

  // page buffer: registered read
  always_ff @(posedge clk) if (bufRdEn) bufRdData <= mem[bufRdAddr];

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  function automatic int gmul(int a, int b);
    int r = 0;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r ^= a;
      a = a << 1;
      if (a[M]) a ^= PRIM;
    end
    return r;
  endfunction

  function automatic int apow(int k);
    int r = 1;
    for (int i = 0; i < k; i++) r = gmul(r, 2);
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference: evaluate polynomial, mark positions, count roots
  task automatic buildExpect(input logic [T*M-1:0] co);
    int cnt = 0, deg = 0;
    for (int j = 1; j <= T; j++) if (co[(j-1)*M +: M] != 0) deg = j;
    for (int p = 1; p <= N; p++) begin
      int x = apow(p - 1), s = 0;
      for (int j = T; j >= 1; j--) s = gmul(s, x) ^ int'(co[(j-1)*M +: M]);
      s = gmul(s, x) ^ 1;
      expBits[p-1] = mem[p-1] ^ (s == 0);
      if (s == 0) cnt++;
    end
    expFail = (cnt != deg);
  endtask

  // Lambda with roots alpha^(e-1) for each listed position e
  function automatic logic [T*M-1:0] makeLambda(int e0, int e1, int e2);
    int c [T+1];
    int pos [3];
    logic [T*M-1:0] r = '0;
    pos[0] = e0; pos[1] = e1; pos[2] = e2;
    c[0] = 1;
    for (int j = 1; j <= T; j++) c[j] = 0;
    for (int i = 0; i < 3; i++) if (pos[i] > 0) begin
      int inv = apow((Q - (pos[i] - 1)) % Q);
      for (int j = T; j >= 1; j--) c[j] ^= gmul(c[j-1], inv);
    end
    for (int j = 1; j <= T; j++) r[(j-1)*M +: M] = M'(c[j]);
    return r;
  endfunction

  task automatic runSearch(input logic [T*M-1:0] co, input bit holdStart, input bit scramble);
    buildExpect(co);
    @(negedge clk);
    start = 1;
    lambdaCoef = co;
    @(negedge clk);  // first negedge after the accepting edge: k = 0
    for (int k = 0; k <= N + 2; k++) begin
      chk(bufRdEn == (k < N), "R2 read enable", bufRdEn, k < N);
      if (k < N) chk(int'(bufRdAddr) == k, "R2 read address", bufRdAddr, k);
      if (holdStart && k < N) chk(int'(bufRdAddr) == k, "R7 start ignored", bufRdAddr, k);
      chk(outValid == (k >= 2 && k <= N + 1), "R3 output valid", outValid, k >= 2 && k <= N + 1);
      if (k >= 2 && k <= N + 1)
        chk(outBit == expBits[k-2], scramble ? "R8 latched coefficient bit" : "R3 corrected bit",
            outBit, expBits[k-2]);
      chk(done == (k == N + 1), "R5 done pulse", done, k == N + 1);
      if (k == N + 1) chk(fail == expFail, scramble ? "R8 fail" : "R6 fail", fail, expFail);
      start = holdStart && (k < N - 2);
      if (scramble) lambdaCoef = lambdaCoef ^ T*M'($urandom);
      @(negedge clk);
    end
    start = 0;
  endtask

  task automatic fillMem(int kind);
    for (int i = 0; i < N; i++)
      case (kind)
        0: mem[i] = 0;
        1: mem[i] = 1;
        2: mem[i] = i[0];
        default: mem[i] = 1'($urandom);
      endcase
  endtask

  initial begin
    fillMem(3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bufRdEn && !outValid && !done && !fail, "R1 reset state",
        {bufRdEn, outValid, done, fail}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!bufRdEn && !outValid && !done && !fail, "R1 idle after reset",
        {bufRdEn, outValid, done, fail}, 0);

    // R4 all-zero coefficients pass data unchanged
    fillMem(2); runSearch('0, 0, 0);
    chk(!fail, "R4 no fail for unit polynomial", fail, 0);
    // single error at first position (x = 1)
    fillMem(0); runSearch(makeLambda(1, 0, 0), 0, 0);
    // three errors incl. last position
    fillMem(1); runSearch(makeLambda(5, 17, N), 0, 0);
    // two errors, random data
    fillMem(3); runSearch(makeLambda(2, 9, 0), 0, 0);
    // R6 polynomial without roots in the field -> fail
    fillMem(3); runSearch({M'(0), M'(1), M'(1)}, 0, 0);
    chk(fail == 1'b1, "R6 fail held after done", fail, 1);
    // R7 start held high throughout
    fillMem(2); runSearch(makeLambda(3, 30, 0), 1, 0);
    // R8 coefficient changes during search
    fillMem(3); runSearch(makeLambda(4, 11, 20), 0, 1);
    // R6 fail cleared by next start: check right after acceptance
    fillMem(0);
    @(negedge clk); start = 1; lambdaCoef = '0;
    @(negedge clk); start = 0;
    chk(!fail, "R6 fail cleared at start", fail, 0);
    repeat (N + 4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule